// File: doc/BRIEF.md
# PTP Transmit Timestamp Capture Writer

This block sits on the transmit side of an Ethernet MAC. For each outgoing frame, software supplies a 2-bit PTP operation flag and a destination memory address. The DMA control stream carries these to the block as sideband user fields, and the block accepts them through a request handshake. The block decodes the flag and drives the MAC's per-frame timestamp operation code. It honours only the two-step mode: the MAC returns the egress timestamp on its sideband ports and leaves the frame unchanged.

Addresses of frames that asked for two-step operation wait in a small FIFO. Several frames can be in flight before their timestamps come back, and the timestamps return in frame order. Each returned timestamp is also queued. When both queues hold an entry, the block issues one write on a simple valid/ready memory write port. The stored word carries the timestamp in its low bits and a qualifier bit at the top. Software polls that qualifier bit to learn that the write has landed. A timestamp that arrives with no waiting two-step frame is discarded and raises a sticky error flag.

A timestamp must arrive at least one cycle after the request of its frame was accepted.

Top module: `ptp_txts_writer`

## Requirements
- R1: After reset, `wr_valid`, `mac_op_vld` and `ts_err` are 0, `mac_op` is 2'b00 and `req_ready` is 1.
- R2: A request accepted with flag 2'b10 (two-step) produces `mac_op_vld`=1 with `mac_op`=2'b10 in the cycle after acceptance.
- R3: A request accepted with flag 2'b00, 2'b01 or 2'b11 produces `mac_op_vld`=1 with `mac_op`=2'b00 in the cycle after acceptance. No memory write results from it, and no entry is queued for it.
- R4: Each write carries the frame's address on `wr_addr`. `wr_data` bits 79:0 hold the returned timestamp, bits 126:80 are zero and bit 127 (the qualifier) is 1.
- R5: Two-step frames are paired with returned timestamps in order: the n-th waiting two-step address is written with the n-th accepted timestamp.
- R6: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R7: In the cycle after a write handshake (`wr_valid` and `wr_ready` both 1), `wr_valid` is 0. A new write starts only after the previous one has completed.
- R8: A timestamp that arrives while no two-step entry is waiting for one is dropped: it produces no write and is never paired with a later frame. It sets `ts_err`.
- R9: When DEPTH two-step addresses are queued and not yet written, `req_ready` is 0. It returns to 1 once a write starts and frees an entry.
- R10: `ts_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Per-frame control entry valid |
| req_ready | output | 1 | Block can accept a control entry |
| req_flag | input | 2 | Software PTP operation flag for the frame |
| req_addr | input | ADDR_W | Memory address for the frame's timestamp |
| mac_op | output | 2 | Timestamp operation code to the MAC |
| mac_op_vld | output | 1 | `mac_op` applies to the frame just accepted |
| ts_valid | input | 1 | MAC egress timestamp valid (one cycle) |
| ts_value | input | TS_W | MAC egress timestamp |
| wr_valid | output | 1 | Memory write request valid |
| wr_ready | input | 1 | Memory write accepted |
| wr_addr | output | ADDR_W | Memory write address |
| wr_data | output | DATA_W | Stored word: timestamp, zero pad, qualifier bit |
| ts_err | output | 1 | Sticky flag: unmatched timestamp was dropped |

## Verification
The assertions check the following on every cycle:
- The operation code never shows the one-step or reserved value.
- The code presented follows the flag of the previous cycle's accepted request.
- Every write word carries the qualifier bit and a zero pad.
- Address and data stay stable under backpressure.
- A write handshake is followed by an idle cycle.
- The error flag never clears on its own and only rises after a timestamp arrives.

Only the bench scenarios can show the following:
- Frame addresses are paired with the right timestamps in order, across mixed flag sequences.
- An orphan timestamp is truly discarded rather than attached to the next frame.
- Unsupported flags leave no queued entry behind.
- Acceptance stops exactly at the queue depth.

// File: rtl/ptp_txts_pkg.sv
package ptp_txts_pkg;

  typedef enum logic [1:0] {
    OP_NONE     = 2'b00,
    OP_ONE_STEP = 2'b01,
    OP_TWO_STEP = 2'b10,
    OP_RSVD     = 2'b11
  } ptp_op_e;

endpackage

// File: rtl/ptp_op_decode.sv
module ptp_op_decode
  import ptp_txts_pkg::*;
(
  input  logic [1:0] flag,
  output logic [1:0] op,
  output logic       two_step
);

  // Only two-step is honoured; one-step and reserved fall back to no-op.
  always_comb begin
    op       = OP_NONE;
    two_step = 1'b0;
    case (ptp_op_e'(flag))
      OP_TWO_STEP: begin
        op       = OP_TWO_STEP;
        two_step = 1'b1;
      end
      default: begin
        op       = OP_NONE;
        two_step = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/ptp_txts_fifo.sv
module ptp_txts_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH):0]     count
);

  // DEPTH must be a power of two, at least 2, so pointers wrap naturally.
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] cnt;

  logic do_push;
  logic do_pop;

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];
  assign count   = cnt;

  // Storage has no reset so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/ptp_txts_wr_master.sv
module ptp_txts_wr_master #(
  parameter int ADDR_W = 32,
  parameter int TS_W   = 80,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [TS_W-1:0]   ts_in,
  output logic              idle,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam int PAD_W = DATA_W - 1 - TS_W;

  logic [DATA_W-1:0] word;

  // Qualifier on top, zero pad, timestamp in the low bits.
  assign word = {1'b1, {PAD_W{1'b0}}, ts_in};
  assign idle = !wr_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (wr_valid) begin
      if (wr_ready) wr_valid <= 1'b0;
    end else if (start) begin
      wr_valid <= 1'b1;
      wr_addr  <= addr_in;
      wr_data  <= word;
    end
  end

endmodule

// File: rtl/ptp_txts_writer.sv
module ptp_txts_writer
  import ptp_txts_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TS_W   = 80,
  parameter int DATA_W = 128,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_flag,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        mac_op,
  output logic              mac_op_vld,
  input  logic              ts_valid,
  input  logic [TS_W-1:0]   ts_value,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              ts_err
);

  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic              accept;
  logic [1:0]        dec_op;
  logic              dec_two;

  logic              a_full, a_empty;
  logic [CNT_W-1:0]  a_cnt;
  logic [ADDR_W-1:0] a_head;

  logic              t_full, t_empty;
  logic [CNT_W-1:0]  t_cnt;
  logic [TS_W-1:0]   t_head;

  logic              orphan;
  logic              t_push;
  logic              wm_idle;
  logic              start;

  assign req_ready = !a_full;
  assign accept    = req_valid && req_ready;

  ptp_op_decode u_dec (
    .flag     (req_flag),
    .op       (dec_op),
    .two_step (dec_two)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mac_op     <= OP_NONE;
      mac_op_vld <= 1'b0;
    end else begin
      mac_op_vld <= accept;
      mac_op     <= accept ? dec_op : OP_NONE;
    end
  end

  ptp_txts_fifo #(.W(ADDR_W), .DEPTH(DEPTH)) u_addr_q (
    .clk   (clk),
    .rst   (rst),
    .push  (accept && dec_two),
    .din   (req_addr),
    .pop   (start),
    .dout  (a_head),
    .full  (a_full),
    .empty (a_empty),
    .count (a_cnt)
  );

  // A timestamp is matched only if more addresses than timestamps are queued.
  assign orphan = ts_valid && ((a_cnt == t_cnt) || t_full);
  assign t_push = ts_valid && !orphan;

  ptp_txts_fifo #(.W(TS_W), .DEPTH(DEPTH)) u_ts_q (
    .clk   (clk),
    .rst   (rst),
    .push  (t_push),
    .din   (ts_value),
    .pop   (start),
    .dout  (t_head),
    .full  (t_full),
    .empty (t_empty),
    .count (t_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst)         ts_err <= 1'b0;
    else if (orphan) ts_err <= 1'b1;
  end

  assign start = wm_idle && !a_empty && !t_empty;

  ptp_txts_wr_master #(.ADDR_W(ADDR_W), .TS_W(TS_W), .DATA_W(DATA_W)) u_wm (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .addr_in  (a_head),
    .ts_in    (t_head),
    .idle     (wm_idle),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

endmodule

// File: rtl/ptp_txts_writer_chk.sv
module ptp_txts_writer_chk #(
  parameter int ADDR_W = 32,
  parameter int TS_W   = 80,
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_flag,
  input logic [1:0]        mac_op,
  input logic              mac_op_vld,
  input logic              ts_valid,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              ts_err
);

  // R2
  op_follow_chk: assert property (@(posedge clk) disable iff (rst)
    mac_op_vld |-> ($past(req_valid && req_ready && !rst) &&
                    (mac_op == (($past(req_flag) == 2'b10) ? 2'b10 : 2'b00))));

  // R3
  no_unsupported_op_chk: assert property (@(posedge clk) disable iff (rst)
    (mac_op != 2'b01) && (mac_op != 2'b11));

  // R4
  word_format_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_data[DATA_W-1] && (wr_data[DATA_W-2:TS_W] == '0)));

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr_valid && !wr_ready && !rst) |-> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R7
  write_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr_valid && wr_ready && !rst) |-> !wr_valid);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ts_err && !rst) |-> ts_err);

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ts_err) |-> $past(ts_valid));

endmodule

bind ptp_txts_writer ptp_txts_writer_chk #(
  .ADDR_W(ADDR_W), .TS_W(TS_W), .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_flag   (req_flag),
  .mac_op     (mac_op),
  .mac_op_vld (mac_op_vld),
  .ts_valid   (ts_valid),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .ts_err     (ts_err)
);

// File: tb/tb_ptp_txts_writer.sv
`timescale 1ns/1ps
module tb_ptp_txts_writer;

  localparam int ADDR_W = 32;
  localparam int TS_W   = 80;
  localparam int DATA_W = 128;
  localparam int DEPTH  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [1:0]        req_flag = 2'b00;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        mac_op;
  logic              mac_op_vld;
  logic              ts_valid = 1'b0;
  logic [TS_W-1:0]   ts_value = '0;
  logic              wr_valid;
  logic              wr_ready = 1'b0;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              ts_err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #4 clk = ~clk;  // 125 MHz

  ptp_txts_writer #(.ADDR_W(ADDR_W), .TS_W(TS_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_flag(req_flag), .req_addr(req_addr),
    .mac_op(mac_op), .mac_op_vld(mac_op_vld),
    .ts_valid(ts_valid), .ts_value(ts_value),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .ts_err(ts_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] word_of(input logic [TS_W-1:0] t);
    return {1'b1, {(DATA_W-1-TS_W){1'b0}}, t};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_req(input logic [1:0] flag, input logic [ADDR_W-1:0] a, input string req);
    logic [1:0] exp_op;
    exp_op = (flag == 2'b10) ? 2'b10 : 2'b00;
    @(negedge clk);
    req_valid = 1'b1; req_flag = flag; req_addr = a;
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(mac_op_vld == 1'b1, req, 128'(mac_op_vld), 128'd1);
    chk(mac_op == exp_op, req, 128'(mac_op), 128'(exp_op));
  endtask

  task automatic send_ts(input logic [TS_W-1:0] t);
    @(negedge clk);
    ts_valid = 1'b1; ts_value = t;
    @(posedge clk); #1;
    ts_valid = 1'b0;
  endtask

  task automatic expect_write(input logic [ADDR_W-1:0] a, input logic [TS_W-1:0] t, input int hold, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (wr_valid) seen = 1'b1;
    end
    chk(seen, req, 128'(seen), 128'd1);
    chk(wr_addr == a, req, 128'(wr_addr), 128'(a));
    chk(wr_data == word_of(t), req, wr_data, word_of(t));
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(wr_valid && wr_addr == a && wr_data == word_of(t), "R6", wr_data, word_of(t));
    end
    wr_ready = 1'b1;
    @(posedge clk); #1;
    wr_ready = 1'b0;
    chk(!wr_valid, "R7", 128'(wr_valid), 128'd0);
  endtask

  task automatic expect_no_write(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wr_valid) seen = 1'b1;
    end
    chk(!seen, req, 128'(seen), 128'd0);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk(!wr_valid, "R1", 128'(wr_valid), 128'd0);
    chk(!mac_op_vld, "R1", 128'(mac_op_vld), 128'd0);
    chk(mac_op == 2'b00, "R1", 128'(mac_op), 128'd0);
    chk(!ts_err, "R1", 128'(ts_err), 128'd0);
    chk(req_ready, "R1", 128'(req_ready), 128'd1);
  endtask

  task automatic t_single();
    send_req(2'b10, 32'h1000_0040, "R2");
    send_ts(80'hABCD_0123_4567_89AB_CDEF);
    expect_write(32'h1000_0040, 80'hABCD_0123_4567_89AB_CDEF, 2, "R4");
  endtask

  task automatic t_other_flags();
    send_req(2'b00, 32'h2000_0000, "R3");
    send_req(2'b01, 32'h2000_0010, "R3");
    send_req(2'b11, 32'h2000_0020, "R3");
    expect_no_write(8, "R3");
    // No entry queued: a timestamp now has nothing to pair with.
    send_ts(80'h1111);
    expect_no_write(6, "R3");
    chk(ts_err, "R3", 128'(ts_err), 128'd1);
    do_reset();
  endtask

  task automatic t_mixed_order();
    send_req(2'b10, 32'hA000_0000, "R2");
    send_req(2'b00, 32'hA000_0100, "R3");
    send_req(2'b10, 32'hA000_0200, "R2");
    send_req(2'b11, 32'hA000_0300, "R3");
    send_req(2'b10, 32'hA000_0400, "R2");
    send_ts(80'h0000_0000_0000_0000_0A01);
    send_ts(80'h0000_0000_0000_0000_0A02);
    send_ts(80'hFFFF_FFFF_FFFF_FFFF_FFFF);
    expect_write(32'hA000_0000, 80'h0A01, 3, "R5");
    expect_write(32'hA000_0200, 80'h0A02, 0, "R5");
    expect_write(32'hA000_0400, 80'hFFFF_FFFF_FFFF_FFFF_FFFF, 1, "R5");
    expect_no_write(4, "R5");
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++)
      send_req(2'b10, 32'hC000_0000 + 32'(i * 16), "R9");
    chk(!req_ready, "R9", 128'(req_ready), 128'd0);
    send_ts(80'h0C00);
    expect_write(32'hC000_0000, 80'h0C00, 1, "R9");
    chk(req_ready, "R9", 128'(req_ready), 128'd1);
    for (int i = 1; i < DEPTH; i++)
      send_ts(80'h0C00 + 80'(i));
    for (int i = 1; i < DEPTH; i++)
      expect_write(32'hC000_0000 + 32'(i * 16), 80'h0C00 + 80'(i), i, "R5");
  endtask

  task automatic t_orphan();
    chk(!ts_err, "R8", 128'(ts_err), 128'd0);
    send_ts(80'hDEAD_BEEF);
    chk(ts_err, "R8", 128'(ts_err), 128'd1);
    expect_no_write(6, "R8");
    send_req(2'b10, 32'hE000_0000, "R2");
    send_ts(80'h0000_5555);
    expect_write(32'hE000_0000, 80'h0000_5555, 0, "R8");
    repeat (5) @(negedge clk);
    chk(ts_err, "R10", 128'(ts_err), 128'd1);
    do_reset();
    @(negedge clk);
    chk(!ts_err, "R10", 128'(ts_err), 128'd0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_other_flags();
    t_mixed_order();
    t_full();
    t_orphan();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule